// File: doc/BRIEF.md
# Synchronized Sample Stream Demultiplexer

This block accepts one sample word per fast clock edge and delivers the stream through one of three output arrangements: a single full-rate port, two half-rate ports that update on alternate edges (interleaved), or two half-rate ports that update together (parallel). Every sample passes through a fixed register pipeline, is recoded to offset binary or two's complement on its way out, and is accompanied by a data clock that a downstream register can use to capture the words.

In the two dual-port arrangements a level sync input steers the stream. Samples taken while sync is high are dropped, so the ports hold their last words. The edge at which sync is first seen low after being high marks an A sample, and the sample after it goes to port B. Without any sync activity after reset, the first sample taken after reset is an A sample. Pad high impedance is modelled by output-enable flags: power-down clears the data enables, and a separate enable governs the data clock.

Top module: `sdm_stream_demux`

## Requirements
- R1: With `mode_sel` = 2'b00 (single, also used for 2'b11), the sample taken at edge N appears on `port_a` after edge N+8, every edge, and `port_b_oe` is low.
- R2: With `mode_sel` = 2'b01 (interleaved), when sync is seen low at edge N after being high at edge N-1, sample N appears on `port_a` after edge N+8 and sample N+1 on `port_b` after edge N+9; the ports then alternate, each holding its word for two edges.
- R3: With `mode_sel` = 2'b10 (parallel), for a pair whose A sample is taken at edge N, `port_a` shows sample N and `port_b` shows sample N+1, both after edge N+9, and both hold through edge N+10.
- R4: In the dual-port modes, a sample taken at an edge where `sync_in` is high is not delivered, so both ports keep their words.
- R5: The A/B phase is re-aligned only by a high-to-low change of sync; after reset, with sync held low, the first sample taken after reset goes to port A. A fall at an odd distance from the previous one still makes its sample an A sample.
- R6: With `fmt_twos` = 0 the output word equals the input code; with `fmt_twos` = 1 bit 7 is inverted (128 gives 0x00, 0 gives 0x80, 255 gives 0x7F, 127 gives 0xFF).
- R7: In parallel mode `dclk_out` is low after each pair-update edge and high after the next; in interleaved mode it is low after a port A update and high after a port B update; in single mode it is the inverse of the clock (low while the clock is high).
- R8: `dclk_oe` follows `dclk_en` one edge later, and `dclk_out` is held low while `dclk_oe` is low.
- R9: After an edge with `pwr_down` high, `port_a_oe` and `port_b_oe` are low in every mode; otherwise `port_a_oe` is high and `port_b_oe` is high only in the dual-port modes.
- R10: In single mode `sync_in` has no effect: the stream continues with sync held high.
- R11: During reset, both ports are zero, all output enables are low and `dclk_out` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sample clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_in | input | 8 | Sample word, one per edge |
| sync_in | input | 1 | Level sync; high drops dual-port samples, a fall marks an A sample |
| mode_sel | input | 2 | 00 single, 01 interleaved, 10 parallel, 11 single |
| fmt_twos | input | 1 | 1 selects two's complement output, 0 offset binary |
| dclk_en | input | 1 | Data clock enable |
| pwr_down | input | 1 | Power-down; clears the data output enables |
| port_a | output | 8 | Port A word (the only port in single mode) |
| port_a_oe | output | 1 | Port A driven flag |
| port_b | output | 8 | Port B word |
| port_b_oe | output | 1 | Port B driven flag |
| dclk_out | output | 1 | Data clock |
| dclk_oe | output | 1 | Data clock driven flag |

## Verification
On every cycle the assertions check that a dropped sample at the output stage leaves both ports unchanged, that the interleaved ports never load on the same edge, and that the enable flags follow power-down, mode and clock enable one edge later. The latencies of each mode, the steering that a sync fall imposes (including the odd-distance re-alignment and the post-reset phase), the code conversion values and the placement of data clock edges relative to word updates are only shown by the bench's scenarios, which compare port values against a history of the samples they drove.

// File: rtl/sdm_pkg.sv
package sdm_pkg;

    typedef enum logic [1:0] {
        MODE_SINGLE     = 2'b00,
        MODE_INTERLEAVE = 2'b01,
        MODE_PARALLEL   = 2'b10,
        MODE_RSVD       = 2'b11
    } out_mode_e;

    typedef enum logic {
        SLOT_B = 1'b0,
        SLOT_A = 1'b1
    } slot_e;

    typedef struct packed {
        logic  valid;
        slot_e slot;
    } tag_t;

    localparam tag_t TAG_EMPTY = '{valid: 1'b0, slot: SLOT_B};

    function automatic out_mode_e decode_mode(input logic [1:0] raw);
        out_mode_e m;
        m = out_mode_e'(raw);
        if (m == MODE_RSVD) begin
            m = MODE_SINGLE;
        end
        return m;
    endfunction

    function automatic logic is_dual(input out_mode_e m);
        return (m == MODE_INTERLEAVE) || (m == MODE_PARALLEL);
    endfunction

    function automatic slot_e other_slot(input slot_e s);
        return (s == SLOT_A) ? SLOT_B : SLOT_A;
    endfunction

endpackage

// File: rtl/sdm_phase_tracker.sv
module sdm_phase_tracker
    import sdm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sync_in,
    input  logic dual_en,
    output tag_t entry_tag
);

    logic  sync_q;
    slot_e slot_q;
    logic  sync_fall;
    slot_e slot_next;

    assign sync_fall = sync_q && !sync_in;

    always_comb begin
        if (sync_fall) begin
            slot_next = SLOT_A;
        end else begin
            slot_next = other_slot(slot_q);
        end
        entry_tag.slot  = slot_next;
        entry_tag.valid = !dual_en || !sync_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= 1'b0;
            slot_q <= SLOT_B;
        end else begin
            sync_q <= sync_in;
            slot_q <= slot_next;
        end
    end

endmodule

// File: rtl/sdm_delay_line.sv
module sdm_delay_line
    import sdm_pkg::*;
#(
    parameter int unsigned WORD_W = 8,
    parameter int unsigned DEPTH  = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] din,
    input  tag_t              tin,
    output logic [WORD_W-1:0] near_data,
    output tag_t              near_tag,
    output logic [WORD_W-1:0] far_data,
    output tag_t              far_tag
);

    localparam int unsigned NEAR_IDX = DEPTH - 2;
    localparam int unsigned FAR_IDX  = DEPTH - 1;

    logic [WORD_W-1:0] dat_q [DEPTH];
    tag_t              tag_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(DEPTH); i++) begin
                dat_q[i] <= '0;
                tag_q[i] <= TAG_EMPTY;
            end
        end else begin
            dat_q[0] <= din;
            tag_q[0] <= tin;
            for (int i = 1; i < int'(DEPTH); i++) begin
                dat_q[i] <= dat_q[i-1];
                tag_q[i] <= tag_q[i-1];
            end
        end
    end

    assign near_data = dat_q[NEAR_IDX];
    assign near_tag  = tag_q[NEAR_IDX];
    assign far_data  = dat_q[FAR_IDX];
    assign far_tag   = tag_q[FAR_IDX];

endmodule

// File: rtl/sdm_port_mux.sv
module sdm_port_mux
    import sdm_pkg::*;
#(
    parameter int unsigned WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  out_mode_e         mode,
    input  logic              fmt_twos,
    input  logic              pwr_down,
    input  logic [WORD_W-1:0] near_data,
    input  tag_t              near_tag,
    input  logic [WORD_W-1:0] far_data,
    input  tag_t              far_tag,
    output logic [WORD_W-1:0] port_a,
    output logic              port_a_oe,
    output logic [WORD_W-1:0] port_b,
    output logic              port_b_oe
);

    localparam int unsigned MSB = WORD_W - 1;

    logic              ld_a;
    logic              ld_b;
    logic              pair_ready;
    logic [WORD_W-1:0] a_src;
    logic [WORD_W-1:0] a_word;
    logic [WORD_W-1:0] b_word;

    function automatic logic [WORD_W-1:0] recode(input logic [WORD_W-1:0] w,
                                                 input logic twos);
        logic [WORD_W-1:0] r;
        r      = w;
        r[MSB] = w[MSB] ^ twos;
        return r;
    endfunction

    assign pair_ready = near_tag.valid && (near_tag.slot == SLOT_B)
                     && far_tag.valid  && (far_tag.slot  == SLOT_A);

    always_comb begin
        ld_a  = 1'b0;
        ld_b  = 1'b0;
        a_src = near_data;
        unique case (mode)
            MODE_INTERLEAVE: begin
                ld_a = near_tag.valid && (near_tag.slot == SLOT_A);
                ld_b = near_tag.valid && (near_tag.slot == SLOT_B);
            end
            MODE_PARALLEL: begin
                ld_a  = pair_ready;
                ld_b  = pair_ready;
                a_src = far_data;
            end
            default: begin
                ld_a = 1'b1;
            end
        endcase
    end

    assign a_word = recode(a_src, fmt_twos);
    assign b_word = recode(near_data, fmt_twos);

    always_ff @(posedge clk) begin
        if (rst) begin
            port_a    <= '0;
            port_b    <= '0;
            port_a_oe <= 1'b0;
            port_b_oe <= 1'b0;
        end else begin
            if (ld_a) begin
                port_a <= a_word;
            end
            if (ld_b) begin
                port_b <= b_word;
            end
            port_a_oe <= !pwr_down;
            port_b_oe <= !pwr_down && is_dual(mode);
        end
    end

    // R4
    drop_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (is_dual(mode) && !near_tag.valid) |=> ($stable(port_a) && $stable(port_b)));

    // R2
    alt_load_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_INTERLEAVE) |-> !(ld_a && ld_b));

    // R9
    pdwn_oe_chk: assert property (@(posedge clk) disable iff (rst)
        pwr_down |=> (!port_a_oe && !port_b_oe));

    // R1
    single_b_off_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_SINGLE) |=> !port_b_oe);

endmodule

// File: rtl/sdm_dclk_gen.sv
module sdm_dclk_gen
    import sdm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  out_mode_e mode,
    input  logic      dclk_en,
    input  slot_e     near_slot,
    output logic      dclk_out,
    output logic      dclk_oe
);

    logic dclk_q;
    logic dclk_next;

    always_comb begin
        if (mode == MODE_PARALLEL) begin
            dclk_next = (near_slot == SLOT_A);
        end else begin
            dclk_next = (near_slot == SLOT_B);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dclk_q  <= 1'b0;
            dclk_oe <= 1'b0;
        end else begin
            dclk_q  <= dclk_next;
            dclk_oe <= dclk_en;
        end
    end

    assign dclk_out = dclk_oe && (is_dual(mode) ? dclk_q : !clk);

    // R8
    dclk_on_chk: assert property (@(posedge clk) disable iff (rst)
        dclk_en |=> dclk_oe);

    // R8
    dclk_off_chk: assert property (@(posedge clk) disable iff (rst)
        !dclk_en |=> (!dclk_oe && !dclk_out));

endmodule

// File: rtl/sdm_stream_demux.sv
module sdm_stream_demux
    import sdm_pkg::*;
#(
    parameter int unsigned WORD_W  = 8,
    parameter int unsigned LATENCY = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] sample_in,
    input  logic              sync_in,
    input  logic [1:0]        mode_sel,
    input  logic              fmt_twos,
    input  logic              dclk_en,
    input  logic              pwr_down,
    output logic [WORD_W-1:0] port_a,
    output logic              port_a_oe,
    output logic [WORD_W-1:0] port_b,
    output logic              port_b_oe,
    output logic              dclk_out,
    output logic              dclk_oe
);

    localparam int unsigned DEPTH = LATENCY + 1;

    out_mode_e         mode;
    tag_t              entry_tag;
    logic [WORD_W-1:0] near_data;
    tag_t              near_tag;
    logic [WORD_W-1:0] far_data;
    tag_t              far_tag;

    assign mode = decode_mode(mode_sel);

    sdm_phase_tracker u_phase (
        .clk       (clk),
        .rst       (rst),
        .sync_in   (sync_in),
        .dual_en   (is_dual(mode)),
        .entry_tag (entry_tag)
    );

    sdm_delay_line #(
        .WORD_W (WORD_W),
        .DEPTH  (DEPTH)
    ) u_delay (
        .clk       (clk),
        .rst       (rst),
        .din       (sample_in),
        .tin       (entry_tag),
        .near_data (near_data),
        .near_tag  (near_tag),
        .far_data  (far_data),
        .far_tag   (far_tag)
    );

    sdm_port_mux #(
        .WORD_W (WORD_W)
    ) u_ports (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .fmt_twos  (fmt_twos),
        .pwr_down  (pwr_down),
        .near_data (near_data),
        .near_tag  (near_tag),
        .far_data  (far_data),
        .far_tag   (far_tag),
        .port_a    (port_a),
        .port_a_oe (port_a_oe),
        .port_b    (port_b),
        .port_b_oe (port_b_oe)
    );

    sdm_dclk_gen u_dclk (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .dclk_en   (dclk_en),
        .near_slot (near_tag.slot),
        .dclk_out  (dclk_out),
        .dclk_oe   (dclk_oe)
    );

endmodule

// File: tb/sdm_stream_demux_bench.sv
module sdm_stream_demux_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] sample_in;
    logic       sync_in;
    logic [1:0] mode_sel;
    logic       fmt_twos;
    logic       dclk_en;
    logic       pwr_down;
    logic [7:0] port_a;
    logic       port_a_oe;
    logic [7:0] port_b;
    logic       port_b_oe;
    logic       dclk_out;
    logic       dclk_oe;

    int errors = 0;
    int checks = 0;
    int eidx   = 0;
    logic [7:0] hist [0:1023];

    always #5 clk = ~clk;

    sdm_stream_demux u_sdm_stream_demux (
        .clk       (clk),
        .rst       (rst),
        .sample_in (sample_in),
        .sync_in   (sync_in),
        .mode_sel  (mode_sel),
        .fmt_twos  (fmt_twos),
        .dclk_en   (dclk_en),
        .pwr_down  (pwr_down),
        .port_a    (port_a),
        .port_a_oe (port_a_oe),
        .port_b    (port_b),
        .port_b_oe (port_b_oe),
        .dclk_out  (dclk_out),
        .dclk_oe   (dclk_oe)
    );

    task automatic tick(input logic [7:0] s);
        sample_in = s;
        hist[eidx % 1024] = s;
        @(posedge clk);
        #1;
        eidx++;
    endtask

    function automatic logic [7:0] h(input int e);
        return hist[e % 1024];
    endfunction

    function automatic logic [7:0] pat(input int j, input int base);
        return 8'((j * 37 + base) % 256);
    endfunction

    task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic t_reset;
        int k;
        rst = 1'b1; mode_sel = 2'b01; sync_in = 1'b0; fmt_twos = 1'b0;
        dclk_en = 1'b1; pwr_down = 1'b0;
        repeat (3) tick(8'h5A);
        chk("R11 port_a in reset", port_a, 8'h00);
        chk("R11 port_b in reset", port_b, 8'h00);
        chk("R11 port_a_oe in reset", {7'd0, port_a_oe}, 8'h00);
        chk("R11 port_b_oe in reset", {7'd0, port_b_oe}, 8'h00);
        chk("R11 dclk_oe in reset", {7'd0, dclk_oe}, 8'h00);
        chk("R11 dclk_out in reset", {7'd0, dclk_out}, 8'h00);
        rst = 1'b0;
        k = eidx;
        for (int j = 0; j < 12; j++) begin
            tick(pat(j, 11));
            if (j == 8) chk("R5 first sample after reset on A", port_a, h(k));
            if (j == 9) begin
                chk("R5 second sample after reset on B", port_b, h(k + 1));
                chk("R9 port_a_oe on in dual", {7'd0, port_a_oe}, 8'h01);
                chk("R9 port_b_oe on in dual", {7'd0, port_b_oe}, 8'h01);
            end
        end
    endtask

    task automatic t_single;
        int s;
        mode_sel = 2'b00; sync_in = 1'b1; fmt_twos = 1'b0;
        s = eidx;
        for (int j = 0; j < 20; j++) begin
            tick(pat(j, 200));
            if (j >= 8) chk("R1 R10 single latency 8 with sync high", port_a, h(s + j - 8));
        end
        chk("R1 port_b_oe off in single", {7'd0, port_b_oe}, 8'h00);
        chk("R7 single dclk low in clock-high phase", {7'd0, dclk_out}, 8'h00);
        #5;
        chk("R7 single dclk high in clock-low phase", {7'd0, dclk_out}, 8'h01);
        sync_in = 1'b0;
    endtask

    task automatic t_format;
        logic [7:0] vin [4];
        logic [7:0] vex [4];
        vin[0] = 8'd128; vin[1] = 8'd0; vin[2] = 8'd255; vin[3] = 8'd127;
        vex[0] = 8'h00;  vex[1] = 8'h80; vex[2] = 8'h7F; vex[3] = 8'hFF;
        mode_sel = 2'b00; fmt_twos = 1'b1;
        for (int j = 0; j < 12; j++) begin
            tick((j < 4) ? vin[j] : 8'h33);
            if (j >= 8) chk("R6 two's complement code", port_a, vex[j - 8]);
        end
        fmt_twos = 1'b0;
        for (int j = 0; j < 9; j++) begin
            tick((j == 0) ? 8'd128 : 8'h44);
        end
        chk("R6 offset binary mid-scale", port_a, 8'h80);
    endtask

    task automatic t_interleave;
        int f;
        logic [7:0] pa;
        logic [7:0] pb;
        mode_sel = 2'b01; sync_in = 1'b1; dclk_en = 1'b1;
        for (int j = 0; j < 12; j++) tick(pat(j, 90));
        pa = port_a; pb = port_b;
        f = eidx;
        for (int j = 0; j < 31; j++) begin
            sync_in = (j >= 11 && j < 17);
            tick(pat(j, 3));
            if (j == 7) begin
                chk("R4 port_a held over dropped samples", port_a, pa);
                chk("R4 port_b held over dropped samples", port_b, pb);
            end
            if (j == 8) begin
                chk("R2 sync-fall sample on A", port_a, h(f));
                chk("R7 interleaved dclk low after A update", {7'd0, dclk_out}, 8'h00);
            end
            if (j == 9) begin
                chk("R2 next sample on B", port_b, h(f + 1));
                chk("R2 A holds while B updates", port_a, h(f));
                chk("R7 interleaved dclk high after B update", {7'd0, dclk_out}, 8'h01);
            end
            if (j == 10) chk("R2 third sample on A", port_a, h(f + 2));
            if (j == 25) chk("R5 odd-distance fall realigns to A", port_a, h(f + 17));
            if (j == 26) chk("R5 sample after realign on B", port_b, h(f + 18));
        end
    endtask

    task automatic t_parallel;
        int p;
        logic [7:0] pa;
        logic [7:0] pb;
        mode_sel = 2'b10; sync_in = 1'b1;
        for (int j = 0; j < 12; j++) tick(pat(j, 150));
        pa = port_a; pb = port_b;
        sync_in = 1'b0;
        p = eidx;
        for (int j = 0; j < 13; j++) begin
            tick(pat(j, 61));
            if (j == 8) begin
                chk("R3 port_a not yet updated", port_a, pa);
                chk("R3 port_b not yet updated", port_b, pb);
            end
            if (j == 9) begin
                chk("R3 A latency 9", port_a, h(p));
                chk("R3 B latency 8", port_b, h(p + 1));
                chk("R7 parallel dclk low after update", {7'd0, dclk_out}, 8'h00);
            end
            if (j == 10) begin
                chk("R3 A holds second cycle", port_a, h(p));
                chk("R7 parallel dclk high mid-way", {7'd0, dclk_out}, 8'h01);
            end
            if (j == 11) begin
                chk("R3 next pair A", port_a, h(p + 2));
                chk("R3 next pair B", port_b, h(p + 3));
            end
        end
    endtask

    task automatic t_powerdown;
        mode_sel = 2'b01; pwr_down = 1'b1;
        tick(8'h01);
        chk("R9 port_a_oe off in interleaved power-down", {7'd0, port_a_oe}, 8'h00);
        chk("R9 port_b_oe off in interleaved power-down", {7'd0, port_b_oe}, 8'h00);
        mode_sel = 2'b10;
        tick(8'h02);
        chk("R9 port_a_oe off in parallel power-down", {7'd0, port_a_oe}, 8'h00);
        mode_sel = 2'b00;
        tick(8'h03);
        chk("R9 port_a_oe off in single power-down", {7'd0, port_a_oe}, 8'h00);
        pwr_down = 1'b0;
        tick(8'h04);
        chk("R9 port_a_oe back on", {7'd0, port_a_oe}, 8'h01);
        chk("R1 port_b_oe stays off in single", {7'd0, port_b_oe}, 8'h00);
        mode_sel = 2'b01;
        tick(8'h05);
        chk("R9 port_b_oe on in dual", {7'd0, port_b_oe}, 8'h01);
    endtask

    task automatic t_dclk_enable;
        mode_sel = 2'b00; dclk_en = 1'b0;
        tick(8'h10);
        chk("R8 dclk_oe off", {7'd0, dclk_oe}, 8'h00);
        #5;
        chk("R8 dclk_out low while disabled", {7'd0, dclk_out}, 8'h00);
        dclk_en = 1'b1;
        tick(8'h11);
        chk("R8 dclk_oe on", {7'd0, dclk_oe}, 8'h01);
    endtask

    initial begin
        rst = 1'b1; sample_in = 8'h00; sync_in = 1'b0; mode_sel = 2'b01;
        fmt_twos = 1'b0; dclk_en = 1'b1; pwr_down = 1'b0;
        @(posedge clk);
        #1;
        t_reset();
        t_single();
        t_format();
        t_interleave();
        t_parallel();
        t_powerdown();
        t_dclk_enable();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule